// File: doc/BRIEF.md
# Skewed 2x2 Systolic Matrix Multiplier

This block multiplies two 2x2 matrices of signed 5-bit values on a small output-stationary systolic grid. Each of the four processing elements takes one operand from its left and one from above. It adds their product into its own accumulator and passes both operands on to its right and lower neighbours one cycle later. A built-in sequencer takes the operands in on a start pulse and clears the accumulators. It then feeds rows from the left edge and columns from the top edge in diagonally staggered wavefronts, drains the grid with zeros and copies the four sums into result registers.

The caller supplies all eight operands in parallel, pulses `start`, and waits until `busy` drops, which happens in the same cycle as the `done` strobe. An optional accumulate mode adds the new product onto the results already held instead of replacing them. This lets a caller build longer sums in steps.

Top module: `smm_array2x2`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` and `done` are 0 and all four results read 0.
- R2: After an operation in overwrite mode, result e equals the exact signed sum over k of A[i][k]*B[k][j], where i = e/2 and j = e%2. Matrix element index e maps row-major (0 = [0][0], 1 = [0][1], 2 = [1][0], 3 = [1][1]). Operand e sits in bits [5e+4:5e] of `a_flat`/`b_flat`, and result e sits in bits [11e+10:11e] of `c_flat`, in two's complement.
- R3: A start pulse seen while idle raises `busy` in the next cycle, and `busy` then stays high for exactly six cycles. This covers the clear step, two feed steps, two flush steps and the latch step.
- R4: `done` is high for exactly one cycle. That cycle is the first one with `busy` low after an operation, and the new results are visible in it.
- R5: A start pulse while `busy` is high is ignored. It does not lengthen the operation, start a second one or change its result.
- R6: Operands and the accumulate flag are captured in the cycle `start` is accepted. Later changes on those inputs do not affect the running operation.
- R7: With `accum` high at start, each result becomes its previous value plus the new product sum.
- R8: Extreme operands give exact results. All entries -16 give 512 in every position, and mixed -16/15 operands give -480 and 481.
- R9: Results do not change in any cycle in which `done` is low, even when the operand inputs change.
- R10: In accumulate mode a sum outside the 11-bit range wraps modulo 2048 (512 + 512 reads back as -1024).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| accum | input | 1 | 1 = add onto held results, 0 = overwrite; sampled with start |
| a_flat | input | 20 | Left matrix, four signed 5-bit entries, row-major |
| b_flat | input | 20 | Right matrix, four signed 5-bit entries, row-major |
| c_flat | output | 44 | Four signed 11-bit results, row-major |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle strobe when results are updated |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a running operation, combined with operand and mode inputs that change after acceptance. In that case a faulty design would restart, extend or re-sample its inputs. The stimulus therefore scrambles the operand inputs on the cycle right after every accepted start. One run also raises `start` with a flipped `accum` and zeroed operands during the second busy cycle. The bench then checks that the busy length is still six and that the results match the originally captured matrices. Wrap-around in accumulate mode is reached by accumulating the all -16 product twice.

// File: rtl/smm_pkg.sv
package smm_pkg;
    parameter int unsigned OPW = 5;
    localparam int unsigned DIM = 2;
    localparam int unsigned NEL = DIM * DIM;
    localparam int unsigned PRODW = 2 * OPW;
    localparam int unsigned ACCW = PRODW + $clog2(DIM);
    localparam int unsigned RUN_LEN = 6;

    typedef logic signed [OPW-1:0]  opnd_t;
    typedef logic signed [ACCW-1:0] acc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_FEED0,
        ST_FEED1,
        ST_FLUSH0,
        ST_FLUSH1,
        ST_LATCH
    } seq_st_e;
endpackage

// File: rtl/smm_pe.sv
module smm_pe
    import smm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  en,
    input  opnd_t a_in,
    input  opnd_t b_in,
    output opnd_t a_out,
    output opnd_t b_out,
    output acc_t  acc
);
    typedef struct packed {
        opnd_t a;
        opnd_t b;
        acc_t  acc;
    } pe_s;

    pe_s cur_q, nxt_d;
    logic signed [PRODW-1:0] prod;

    always_comb begin
        prod  = PRODW'(a_in) * PRODW'(b_in);
        nxt_d = cur_q;
        if (clr) begin
            nxt_d = '0;
        end else if (en) begin
            nxt_d.a   = a_in;
            nxt_d.b   = b_in;
            nxt_d.acc = cur_q.acc + acc_t'(prod);
        end else begin
            nxt_d.a = '0;
            nxt_d.b = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign a_out = cur_q.a;
    assign b_out = cur_q.b;
    assign acc   = cur_q.acc;
endmodule

// File: rtl/smm_seq.sv
module smm_seq
    import smm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    accum,
    output seq_st_e st,
    output logic    busy,
    output logic    done,
    output logic    take,
    output logic    mode
);
    typedef struct packed {
        seq_st_e st;
        logic    done;
        logic    mode;
    } seq_s;

    seq_s cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        take       = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    take       = 1'b1;
                    nxt_d.st   = ST_CLEAR;
                    nxt_d.mode = accum;
                end
            end
            ST_CLEAR:  nxt_d.st = ST_FEED0;
            ST_FEED0:  nxt_d.st = ST_FEED1;
            ST_FEED1:  nxt_d.st = ST_FLUSH0;
            ST_FLUSH0: nxt_d.st = ST_FLUSH1;
            ST_FLUSH1: nxt_d.st = ST_LATCH;
            ST_LATCH: begin
                nxt_d.st   = ST_IDLE;
                nxt_d.done = 1'b1;
            end
            default:   nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st   <= ST_IDLE;
            cur_q.done <= 1'b0;
            cur_q.mode <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign st   = cur_q.st;
    assign busy = (cur_q.st != ST_IDLE);
    assign done = cur_q.done;
    assign mode = cur_q.mode;
endmodule

// File: rtl/smm_array2x2.sv
module smm_array2x2
    import smm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  accum,
    input  logic [NEL*OPW-1:0]    a_flat,
    input  logic [NEL*OPW-1:0]    b_flat,
    output logic [NEL*ACCW-1:0]   c_flat,
    output logic                  busy,
    output logic                  done
);
    typedef struct packed {
        logic [NEL-1:0][OPW-1:0]  a;
        logic [NEL-1:0][OPW-1:0]  b;
        logic [NEL-1:0][ACCW-1:0] res;
    } top_s;

    top_s    cur_q, nxt_d;
    seq_st_e st;
    logic    take, mode;
    logic    pe_clr, pe_en;

    opnd_t left_w [DIM];
    opnd_t top_w  [DIM];
    opnd_t pa_in  [DIM][DIM];
    opnd_t pb_in  [DIM][DIM];
    opnd_t pa_out [DIM][DIM];
    opnd_t pb_out [DIM][DIM];
    acc_t  pacc   [DIM][DIM];
    acc_t  acc_w  [NEL];

    smm_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .accum (accum),
        .st    (st),
        .busy  (busy),
        .done  (done),
        .take  (take),
        .mode  (mode)
    );

    assign pe_clr = (st == ST_CLEAR);
    assign pe_en  = (st == ST_FEED0) || (st == ST_FEED1) ||
                    (st == ST_FLUSH0) || (st == ST_FLUSH1);

    // Edge injection: row r / column c lag by r / c steps behind step 0.
    always_comb begin
        int step;
        step = -1;
        case (st)
            ST_FEED0:  step = 0;
            ST_FEED1:  step = 1;
            ST_FLUSH0: step = 2;
            default:   step = -1;
        endcase
        for (int r = 0; r < DIM; r++) begin
            int k;
            k = step - r;
            left_w[r] = '0;
            top_w[r]  = '0;
            if (step >= 0 && k >= 0 && k < DIM) begin
                left_w[r] = $signed(cur_q.a[r*DIM + k]);
                top_w[r]  = $signed(cur_q.b[k*DIM + r]);
            end
        end
    end

    for (genvar gi = 0; gi < DIM; gi++) begin : g_row
        for (genvar gj = 0; gj < DIM; gj++) begin : g_col
            if (gj == 0) begin : g_ledge
                assign pa_in[gi][gj] = left_w[gi];
            end else begin : g_lfwd
                assign pa_in[gi][gj] = pa_out[gi][gj-1];
            end
            if (gi == 0) begin : g_tedge
                assign pb_in[gi][gj] = top_w[gj];
            end else begin : g_tfwd
                assign pb_in[gi][gj] = pb_out[gi-1][gj];
            end

            smm_pe u_pe (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (pe_clr),
                .en    (pe_en),
                .a_in  (pa_in[gi][gj]),
                .b_in  (pb_in[gi][gj]),
                .a_out (pa_out[gi][gj]),
                .b_out (pb_out[gi][gj]),
                .acc   (pacc[gi][gj])
            );

            assign acc_w[gi*DIM + gj] = pacc[gi][gj];
        end
    end

    always_comb begin
        nxt_d = cur_q;
        if (take) begin
            nxt_d.a = a_flat;
            nxt_d.b = b_flat;
        end
        if (st == ST_LATCH) begin
            for (int e = 0; e < NEL; e++) begin
                if (mode) nxt_d.res[e] = $signed(cur_q.res[e]) + acc_w[e];
                else      nxt_d.res[e] = acc_w[e];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign c_flat = cur_q.res;
endmodule

// File: rtl/smm_chk.sv
module smm_chk
    import smm_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [NEL*ACCW-1:0] c_flat
);
    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 4'd1;
        else           run_q <= '0;
    end

    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 4'(RUN_LEN)));

    // R5
    busy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < 4'(RUN_LEN)));

    // R4
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R4
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(c_flat));
endmodule

bind smm_array2x2 smm_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .c_flat (c_flat)
);

// File: tb/sim_smm_array2x2.sv
module sim_smm_array2x2;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        accum = 1'b0;
    logic [19:0] a_flat = '0;
    logic [19:0] b_flat = '0;
    logic [43:0] c_flat;
    logic        busy, done;

    int checks = 0;
    int fails = 0;
    int model [4] = '{0, 0, 0, 0};

    always #4 clk = ~clk;

    smm_array2x2 u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .accum(accum),
        .a_flat(a_flat), .b_flat(b_flat), .c_flat(c_flat),
        .busy(busy), .done(done)
    );

    localparam int VT [6][8] = '{
        '{  1,   0,   0,   1,    3,  -2,   7,   4},
        '{  2,  -3,   4,   5,   -1,   6,   7,  -8},
        '{-16, -16, -16, -16,  -16, -16, -16, -16},
        '{-16,  15,  15, -16,   15, -16, -16,  15},
        '{  0,   0,   0,   0,    9,  -9,   5,   3},
        '{ 15,  15,  15,  15,   15,  15,  15,  15}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wrap11(input int x);
        int r;
        r = x & 2047;
        if (r >= 1024) r = r - 2048;
        return r;
    endfunction

    function automatic int rd(input int e);
        logic signed [10:0] v;
        v = c_flat[e*11 +: 11];
        return int'(v);
    endfunction

    function automatic logic [19:0] pk(input int v0, input int v1, input int v2, input int v3);
        logic [4:0] p0, p1, p2, p3;
        p0 = v0[4:0]; p1 = v1[4:0]; p2 = v2[4:0]; p3 = v3[4:0];
        return {p3, p2, p1, p0};
    endfunction

    task automatic run(input int av[4], input int bv[4], input bit acc,
                       input bit intrude, input string tag);
        int exp [4];
        int n;
        for (int e = 0; e < 4; e++) begin
            int i, j, p;
            i = e / 2;
            j = e % 2;
            p = av[i*2] * bv[j] + av[i*2+1] * bv[2+j];
            exp[e] = acc ? wrap11(model[e] + p) : wrap11(p);
        end
        a_flat = pk(av[0], av[1], av[2], av[3]);
        b_flat = pk(bv[0], bv[1], bv[2], bv[3]);
        accum  = acc;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        // R6: scramble inputs right after acceptance
        a_flat = ~a_flat;
        b_flat = b_flat ^ 20'h5A5A5;
        accum  = ~acc;
        n = 0;
        while (busy && n < 20) begin
            n++;
            if (intrude && n == 2) begin
                start  = 1'b1;
                a_flat = '0;
                b_flat = '0;
            end
            if (n == 3) start = 1'b0;
            @(negedge clk);
        end
        chk(n == 6, "R3 busy length", n, 6);
        chk(done == 1'b1, "R4 done at end", int'(done), 1);
        for (int e = 0; e < 4; e++) begin
            chk(rd(e) == exp[e], tag, rd(e), exp[e]);
            model[e] = exp[e];
        end
        @(negedge clk);
        chk(done == 1'b0, "R4 done single", int'(done), 0);
        if (intrude) chk(busy == 1'b0, "R5 no restart", int'(busy), 0);
        // R9: results hold while idle with changing inputs
        a_flat = 20'h0F0F0;
        @(negedge clk);
        for (int e = 0; e < 4; e++) chk(rd(e) == model[e], "R9 hold", rd(e), model[e]);
        accum = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        int av[4];
        int bv[4];
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(c_flat == '0, "R1 results", int'(c_flat[31:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && c_flat == '0, "R1 after release", int'(busy), 0);

        // R2 / R8 table walk
        for (int t = 0; t < 6; t++) begin
            for (int e = 0; e < 4; e++) begin
                av[e] = VT[t][e];
                bv[e] = VT[t][4+e];
            end
            run(av, bv, 1'b0, 1'b0, (t == 2 || t == 3) ? "R8 extreme" : "R2 product");
        end

        // R7 accumulate onto identity x B
        av = '{1, 0, 0, 1};
        bv = '{3, -2, 7, 4};
        run(av, bv, 1'b0, 1'b0, "R2 product");
        av = '{1, 1, 1, 1};
        bv = '{1, 2, 3, 4};
        run(av, bv, 1'b1, 1'b0, "R7 accumulate");

        // R10 wrap in accumulate mode
        av = '{-16, -16, -16, -16};
        bv = '{-16, -16, -16, -16};
        run(av, bv, 1'b0, 1'b0, "R8 extreme");
        run(av, bv, 1'b1, 1'b0, "R10 wrap");
        chk(rd(0) == -1024, "R10 wrap value", rd(0), -1024);

        // R5 start while busy ignored (mode flipped, operands zeroed)
        av = '{2, -3, 4, 5};
        bv = '{-1, 6, 7, -8};
        run(av, bv, 1'b0, 1'b1, "R5 intrude result");

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule